// File: doc/BRIEF.md
# Channel Status Bit Stream Generator

This block supplies the channel status bit for each frame of a two-channel digital audio transmitter. Its frame strobe pulses once per left/right subframe pair, and it tracks the frame's position in the 192-frame channel status block. For that position it registers the bit the subframe formatter must insert. The bit comes from two sources. One is a serial channel status input, sampled on the frame strobe. The other is a set of static configuration pins, which the block maps onto fixed bit positions.

A mode input selects one of two pin maps. In consumer mode the dedicated pins are active-low, and a two-bit frequency code is translated onto bits 24 and 25. In professional mode a two-bit emphasis code is expanded onto bits 2 to 4, and plain active-high pins drive bits 1, 6, 7 and 9. The pin-derived value is ORed with the serial bit. A transparent input bypasses every pin, so the serial stream passes untouched. A block-start strobe aligns the position counter, and a flag output marks frame 0 of each block.

Top module: `cs_bit_gen`

## Requirements
- R1: After reset, `cs_bit` and `blk_flag` are 0 and stay 0 on every frame strobe until the first frame strobe that carries `block_start`, whatever the other inputs are.
- R2: A frame strobe with `block_start` high makes that frame position 0. Every other frame strobe advances the position by one, and position 191 wraps to 0. `blk_flag` is 1 exactly while the last issued frame was position 0.
- R3: `cs_bit` and `blk_flag` change only in the clock cycle after a frame strobe, and hold their value between strobes.
- R4: In consumer mode (`consumer_mode`=1) with transparent mode off, position 0 is always sent as 0, even when the serial bit is 1.
- R5: In consumer mode with transparent mode off, positions 2, 3, 8, 9 and 15 are sent as the serial bit ORed with the inverse of `con_copy_n`, `con_emph_n`, `con_cat0_n`, `con_cat1_n` and `con_gen_n` respectively.
- R6: In consumer mode with transparent mode off, the code {`fcode_hi`,`fcode_lo`} gives bits {24,25} of 00→00, 01→01, 10→11, 11→00, each ORed with the serial bit.
- R7: `cd_sub` is 1 exactly when `consumer_mode`=1 and both `fcode_hi` and `fcode_lo` are 1.
- R8: In professional mode (`consumer_mode`=0) with transparent mode off, {`emph_hi`,`emph_lo`} gives bits {2,3,4} of 00→111, 01→110, 10→100, 11→000, each ORed with the serial bit.
- R9: In professional mode with transparent mode off, positions 1, 6, 7 and 9 are sent as the serial bit ORed with `pro_nonaudio`, `pro_fs_a`, `pro_fs_b` and `pro_chmode` respectively.
- R10: With `transparent`=1, every position is sent as the serial bit, in either mode.
- R11: Every position that the current mode does not map to a pin is sent as the serial bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe per frame |
| block_start | input | 1 | Marks the strobed frame as block position 0 |
| serial_cs | input | 1 | Serial channel status bit, sampled with frame_tick |
| consumer_mode | input | 1 | 1 selects consumer mode, 0 selects professional mode |
| transparent | input | 1 | 1 bypasses every configuration pin |
| con_copy_n | input | 1 | Consumer bit 2 pin, active-low |
| con_emph_n | input | 1 | Consumer bit 3 pin, active-low |
| con_cat0_n | input | 1 | Consumer bit 8 pin, active-low |
| con_cat1_n | input | 1 | Consumer bit 9 pin, active-low |
| con_gen_n | input | 1 | Consumer bit 15 pin, active-low |
| fcode_hi | input | 1 | Consumer frequency code, upper bit |
| fcode_lo | input | 1 | Consumer frequency code, lower bit |
| emph_hi | input | 1 | Professional emphasis code, upper bit |
| emph_lo | input | 1 | Professional emphasis code, lower bit |
| pro_nonaudio | input | 1 | Professional bit 1 pin |
| pro_fs_a | input | 1 | Professional bit 6 pin |
| pro_fs_b | input | 1 | Professional bit 7 pin |
| pro_chmode | input | 1 | Professional bit 9 pin |
| cs_bit | output | 1 | Registered channel status bit for the current frame |
| blk_flag | output | 1 | High while the current frame is block position 0 |
| cd_sub | output | 1 | CD submode indication |

## Verification
The hardest condition to reach from the ports is the counter wrap from 191 to 0 without a block-start strobe. The same applies to a block start arriving mid-block. Both need long runs of frames with exact position bookkeeping. The bench therefore runs some blocks with `block_start` held low after the first, so the counter must wrap on its own. It also forces a restart at position 50 and checks that position 0 is then forced to 0 against a serial 1. Every frequency code and every emphasis code is swept over a full 192-frame block, once with a zero serial stream and once with a mixed serial stream. This makes the pin contribution and the OR visible at every position.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int BLOCK_LEN = 192;
    localparam int POS_W     = $clog2(BLOCK_LEN);

    typedef enum logic {
        MODE_PRO  = 1'b0,
        MODE_CONS = 1'b1
    } cs_mode_e;

    // consumer pin group; the five single pins are active-low
    typedef struct packed {
        logic       copy_n;
        logic       emph_n;
        logic       cat0_n;
        logic       cat1_n;
        logic       gen_n;
        logic [1:0] fcode;
    } cons_pins_t;

    // professional pin group, active-high
    typedef struct packed {
        logic [1:0] emph;
        logic       nonaudio;
        logic       fs_a;
        logic       fs_b;
        logic       chmode;
    } pro_pins_t;

    // result of the pin mapping for one position
    typedef struct packed {
        logic force_zero;
        logic pin_bit;
    } pin_term_t;

    // frequency code -> {bit24, bit25}
    function automatic logic [1:0] fcode_to_bits(input logic [1:0] fc);
        case (fc)
            2'b01:   return 2'b01;
            2'b10:   return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    // emphasis code -> {bit2, bit3, bit4}
    function automatic logic [2:0] emph_to_bits(input logic [1:0] em);
        case (em)
            2'b00:   return 3'b111;
            2'b01:   return 3'b110;
            2'b10:   return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/cs_pos_counter.sv
module cs_pos_counter #(
    parameter int BLOCK_LEN = cs_pkg::BLOCK_LEN,
    localparam int POS_W    = $clog2(BLOCK_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic             block_start,
    output logic [POS_W-1:0] frame_pos,
    output logic             frame_valid
);
    localparam logic [POS_W-1:0] LAST = POS_W'(BLOCK_LEN - 1);

    logic [POS_W-1:0] cnt_q;
    logic             synced_q;

    always_comb begin
        if (block_start)
            frame_pos = '0;
        else if (cnt_q == LAST)
            frame_pos = '0;
        else
            frame_pos = cnt_q + 1'b1;
        frame_valid = synced_q | block_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            synced_q <= 1'b0;
        end else if (frame_tick && frame_valid) begin
            cnt_q    <= frame_pos;
            synced_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cs_pin_mapper.sv
module cs_pin_mapper
    import cs_pkg::*;
#(
    parameter int POS_W = cs_pkg::POS_W
) (
    input  logic [POS_W-1:0] pos,
    input  cs_mode_e         mode,
    input  cons_pins_t       cons,
    input  pro_pins_t        pro,
    output pin_term_t        term
);
    logic [1:0] fbits;
    logic [2:0] ebits;

    always_comb begin
        fbits = fcode_to_bits(cons.fcode);
        ebits = emph_to_bits(pro.emph);
        term  = '0;
        if (mode == MODE_CONS) begin
            case (int'(pos))
                0:  term.force_zero = 1'b1;
                2:  term.pin_bit    = ~cons.copy_n;
                3:  term.pin_bit    = ~cons.emph_n;
                8:  term.pin_bit    = ~cons.cat0_n;
                9:  term.pin_bit    = ~cons.cat1_n;
                15: term.pin_bit    = ~cons.gen_n;
                24: term.pin_bit    = fbits[1];
                25: term.pin_bit    = fbits[0];
                default: term       = '0;
            endcase
        end else begin
            case (int'(pos))
                1: term.pin_bit = pro.nonaudio;
                2: term.pin_bit = ebits[2];
                3: term.pin_bit = ebits[1];
                4: term.pin_bit = ebits[0];
                6: term.pin_bit = pro.fs_a;
                7: term.pin_bit = pro.fs_b;
                9: term.pin_bit = pro.chmode;
                default: term   = '0;
            endcase
        end
    end
endmodule

// File: rtl/cs_bit_gen.sv
module cs_bit_gen
    import cs_pkg::*;
#(
    parameter int BLOCK_LEN = cs_pkg::BLOCK_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_tick,
    input  logic block_start,
    input  logic serial_cs,
    input  logic consumer_mode,
    input  logic transparent,
    input  logic con_copy_n,
    input  logic con_emph_n,
    input  logic con_cat0_n,
    input  logic con_cat1_n,
    input  logic con_gen_n,
    input  logic fcode_hi,
    input  logic fcode_lo,
    input  logic emph_hi,
    input  logic emph_lo,
    input  logic pro_nonaudio,
    input  logic pro_fs_a,
    input  logic pro_fs_b,
    input  logic pro_chmode,
    output logic cs_bit,
    output logic blk_flag,
    output logic cd_sub
);
    localparam int POS_W = $clog2(BLOCK_LEN);

    logic [POS_W-1:0] frame_pos;
    logic             frame_valid;
    cs_mode_e         mode;
    cons_pins_t       cons;
    pro_pins_t        pro;
    pin_term_t        term;
    logic             merged;
    logic             cs_q;
    logic             blk_q;

    assign mode = consumer_mode ? MODE_CONS : MODE_PRO;
    assign cons = '{copy_n: con_copy_n, emph_n: con_emph_n, cat0_n: con_cat0_n,
                    cat1_n: con_cat1_n, gen_n: con_gen_n,
                    fcode: {fcode_hi, fcode_lo}};
    assign pro  = '{emph: {emph_hi, emph_lo}, nonaudio: pro_nonaudio,
                    fs_a: pro_fs_a, fs_b: pro_fs_b, chmode: pro_chmode};

    cs_pos_counter #(.BLOCK_LEN(BLOCK_LEN)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .frame_tick  (frame_tick),
        .block_start (block_start),
        .frame_pos   (frame_pos),
        .frame_valid (frame_valid)
    );

    cs_pin_mapper #(.POS_W(POS_W)) u_map (
        .pos  (frame_pos),
        .mode (mode),
        .cons (cons),
        .pro  (pro),
        .term (term)
    );

    always_comb begin
        if (transparent)
            merged = serial_cs;
        else if (term.force_zero)
            merged = 1'b0;
        else
            merged = serial_cs | term.pin_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b0;
            blk_q <= 1'b0;
        end else if (frame_tick) begin
            cs_q  <= frame_valid & merged;
            blk_q <= frame_valid & (frame_pos == '0);
        end
    end

    assign cs_bit   = cs_q;
    assign blk_flag = blk_q;
    assign cd_sub   = (mode == MODE_CONS) & fcode_hi & fcode_lo;
endmodule

// File: rtl/cs_bit_gen_chk.sv
module cs_bit_gen_chk #(
    parameter int POS_W     = 8,
    parameter int BLOCK_LEN = 192
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_tick,
    input logic             block_start,
    input logic             serial_cs,
    input logic             consumer_mode,
    input logic             transparent,
    input logic [POS_W-1:0] frame_pos,
    input logic             cs_bit,
    input logic             blk_flag,
    input logic             cd_sub
);
    logic seen_start;

    always_ff @(posedge clk) begin
        if (rst)
            seen_start <= 1'b0;
        else if (frame_tick && block_start)
            seen_start <= 1'b1;
    end

    AST_PRESYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
        !seen_start |-> (!cs_bit && !blk_flag)); // R1

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(frame_pos) < BLOCK_LEN); // R2

    AST_START_FLAG: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && block_start) |=> blk_flag); // R2

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> ($stable(cs_bit) && $stable(blk_flag))); // R3

    AST_CONS_BIT0_ZERO: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && block_start && consumer_mode && !transparent) |=> !cs_bit); // R4

    AST_PRO_NO_CD: assert property (@(posedge clk) disable iff (rst)
        !consumer_mode |-> !cd_sub); // R7

    AST_TRANSPARENT_PASS: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && transparent && (seen_start || block_start))
        |=> (cs_bit == $past(serial_cs))); // R10
endmodule

bind cs_bit_gen cs_bit_gen_chk #(.POS_W(POS_W), .BLOCK_LEN(BLOCK_LEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_tick    (frame_tick),
    .block_start   (block_start),
    .serial_cs     (serial_cs),
    .consumer_mode (consumer_mode),
    .transparent   (transparent),
    .frame_pos     (frame_pos),
    .cs_bit        (cs_bit),
    .blk_flag      (blk_flag),
    .cd_sub        (cd_sub)
);

// File: tb/tb_cs_bit_gen.sv
`timescale 1ns/1ps
module tb_cs_bit_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_tick = 0, block_start = 0, serial_cs = 0;
    logic consumer_mode = 0, transparent = 0;
    logic con_copy_n = 0, con_emph_n = 0, con_cat0_n = 0, con_cat1_n = 0, con_gen_n = 0;
    logic fcode_hi = 0, fcode_lo = 0, emph_hi = 0, emph_lo = 0;
    logic pro_nonaudio = 0, pro_fs_a = 0, pro_fs_b = 0, pro_chmode = 0;
    logic cs_bit, blk_flag, cd_sub;

    int n_tests = 0;
    int n_fail  = 0;
    int cur_pos = 0;

    always #4 clk = ~clk;

    cs_bit_gen dut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .block_start(block_start),
        .serial_cs(serial_cs), .consumer_mode(consumer_mode), .transparent(transparent),
        .con_copy_n(con_copy_n), .con_emph_n(con_emph_n), .con_cat0_n(con_cat0_n),
        .con_cat1_n(con_cat1_n), .con_gen_n(con_gen_n), .fcode_hi(fcode_hi),
        .fcode_lo(fcode_lo), .emph_hi(emph_hi), .emph_lo(emph_lo),
        .pro_nonaudio(pro_nonaudio), .pro_fs_a(pro_fs_a), .pro_fs_b(pro_fs_b),
        .pro_chmode(pro_chmode), .cs_bit(cs_bit), .blk_flag(blk_flag), .cd_sub(cd_sub)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s pos=%0d actual=%b expected=%b", req, cur_pos, act, exp);
        end
    endtask

    // expected bit, computed from the requirement text
    function automatic logic exp_bit(input int p, input logic s);
        int fc = {fcode_hi, fcode_lo};
        int em = {emph_hi, emph_lo};
        if (transparent) return s;                        // R10
        if (consumer_mode) begin
            case (p)
                0:  return 1'b0;                          // R4
                2:  return s | ~con_copy_n;               // R5
                3:  return s | ~con_emph_n;
                8:  return s | ~con_cat0_n;
                9:  return s | ~con_cat1_n;
                15: return s | ~con_gen_n;
                24: return s | (fc == 2);                 // R6
                25: return s | (fc == 1 || fc == 2);
                default: return s;                        // R11
            endcase
        end else begin
            case (p)
                1: return s | pro_nonaudio;               // R9
                2: return s | (em != 3);                  // R8
                3: return s | (em < 2);
                4: return s | (em == 0);
                6: return s | pro_fs_a;
                7: return s | pro_fs_b;
                9: return s | pro_chmode;
                default: return s;                        // R11
            endcase
        end
    endfunction

    function automatic logic pattern(input int p, input int seed);
        if (seed < 0) return 1'b0;
        return (((p * 5 + seed) % 3) == 0);
    endfunction

    // one frame: strobe at negedge, sample at the following negedge
    task automatic frame(input int p, input logic start, input logic s, input string req);
        @(negedge clk);
        frame_tick  = 1'b1;
        block_start = start;
        serial_cs   = s;
        cur_pos     = p;
        @(negedge clk);
        frame_tick  = 1'b0;
        block_start = 1'b0;
        check(req, cs_bit, exp_bit(p, s));
        check("R2 blk_flag", blk_flag, (p == 0));
    endtask

    task automatic run_block(input logic with_start, input int seed, input string req);
        for (int p = 0; p < 192; p++)
            frame(p, with_start && (p == 0), pattern(p, seed), req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset cs_bit", cs_bit, 1'b0);
        check("R1 reset blk_flag", blk_flag, 1'b0);

        // R1: strobes before any block start keep outputs low
        transparent = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); frame_tick = 1'b1; serial_cs = 1'b1;
            @(negedge clk); frame_tick = 1'b0;
            check("R1 presync cs_bit", cs_bit, 1'b0);
            check("R1 presync blk_flag", blk_flag, 1'b0);
        end
        transparent = 1'b0;

        // consumer sweep over all frequency codes (R4 R5 R6 R7 R11)
        consumer_mode = 1'b1;
        for (int fc = 0; fc < 4; fc++) begin
            {fcode_hi, fcode_lo} = fc[1:0];
            {con_copy_n, con_emph_n, con_cat0_n, con_cat1_n, con_gen_n} = 5'(fc * 9 + 5);
            #1 check("R7 cd_sub consumer", cd_sub, (fc == 3));
            run_block(1'b1, -1, "R5 R6 consumer zero-serial");
            run_block(1'b1, fc, "R4 R5 R6 R11 consumer pattern");
        end

        // R2: wrap 191 -> 0 without a block start
        run_block(1'b0, 7, "R2 consumer wrap");

        // professional sweep over all emphasis codes (R8 R9 R11)
        consumer_mode = 1'b0;
        {fcode_hi, fcode_lo} = 2'b11;
        #1 check("R7 cd_sub pro", cd_sub, 1'b0);
        for (int em = 0; em < 4; em++) begin
            {emph_hi, emph_lo} = em[1:0];
            {pro_nonaudio, pro_fs_a, pro_fs_b, pro_chmode} = 4'(em * 5 + 3);
            run_block(1'b1, -1, "R8 R9 pro zero-serial");
            run_block(1'b1, em + 1, "R8 R9 R11 pro pattern");
        end
        run_block(1'b0, 2, "R2 pro wrap");

        // R10: transparent in both modes with all pins asserting
        transparent = 1'b1;
        {pro_nonaudio, pro_fs_a, pro_fs_b, pro_chmode} = 4'hF;
        {emph_hi, emph_lo} = 2'b00;
        run_block(1'b1, -1, "R10 pro transparent");
        consumer_mode = 1'b1;
        {con_copy_n, con_emph_n, con_cat0_n, con_cat1_n, con_gen_n} = 5'b0;
        {fcode_hi, fcode_lo} = 2'b10;
        run_block(1'b1, 1, "R10 consumer transparent");
        transparent = 1'b0;

        // R2 R4: restart mid-block at position 50
        for (int p = 0; p <= 50; p++) frame(p, p == 0, 1'b0, "R2 pre-restart");
        frame(0, 1'b1, 1'b1, "R4 restart bit0 forced zero");
        for (int p = 1; p < 30; p++) frame(p, 1'b0, pattern(p, 4), "R2 post-restart");

        // R3: output holds between strobes while serial input toggles
        frame(30, 1'b0, 1'b1, "R3 setup");
        for (int i = 0; i < 4; i++) begin
            serial_cs = i[0];
            @(negedge clk);
            check("R3 hold cs_bit", cs_bit, 1'b1);
            check("R3 hold blk_flag", blk_flag, 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule